// File: doc/BRIEF.md
# Integer ALU with Stored Condition Flags

This block is the execute stage of a small 32-bit integer datapath. It combines two operands under a 4-bit operation code (add, subtract, AND, XOR). When the caller raises the flag-update strobe, the block keeps zero, sign and signed-overflow flags from that result in a register. The result is combinational. The flags change only on a clock edge.

A separate 4-bit condition code is tested against the stored flags, never against the live result. The test gives a single take/move decision that serves both conditional branches and conditional register copies. Codes outside the defined sets are reported on an invalid-function output. They never produce a result, a taken condition or a flag update.

Top module: `alu_cc_unit`

## Requirements
- R1: `result_o` is combinational and follows `alu_fn_i`. Code 0 gives `op_b_i + op_a_i`. Code 1 gives `op_b_i - op_a_i` (the B operand is the minuend). Code 2 gives `op_a_i & op_b_i`. Code 3 gives `op_a_i ^ op_b_i`. All arithmetic wraps modulo 2^32.
- R2: On a rising `clk_i` edge with `set_cc_i`=1 and a valid ALU code, `zf_o` becomes 1 exactly when the result was zero, and `sf_o` becomes bit 31 of the result.
- R3: On such an update, `of_o` is set as follows. For add, it is 1 when both operands share a sign and the result's sign differs from it. For subtract, it is 1 when the operand signs differ and the result's sign differs from `op_b_i`'s sign. For AND and XOR, it is 0.
- R4: When `set_cc_i`=0 at a rising edge, the three flags keep their values.
- R5: While `rst_ni`=0 (asynchronous, active low), the flags are zf=1, sf=0 and of=0.
- R6: `cond_true_o` is combinational in `cond_fn_i` and the stored flags. Code 0 is always 1. Code 1 is (sf^of)|zf. Code 2 is sf^of. Code 3 is zf. Code 4 is !zf. Code 5 is !(sf^of). Code 6 is !(sf^of)&!zf.
- R7: For ALU codes 4 to 15, `result_o` is 0, `fn_invalid_o` is 1, and a `set_cc_i` edge leaves the flags unchanged.
- R8: For condition codes 7 to 15, `cond_true_o` is 0 and `fn_invalid_o` is 1.
- R9: `fn_invalid_o` is 0 whenever both codes are in their valid ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B (minuend for subtract) |
| alu_fn_i | input | 4 | Operation code |
| set_cc_i | input | 1 | Flag-update strobe |
| cond_fn_i | input | 4 | Condition code |
| result_o | output | 32 | Operation result |
| zf_o | output | 1 | Stored zero flag |
| sf_o | output | 1 | Stored sign flag |
| of_o | output | 1 | Stored overflow flag |
| cond_true_o | output | 1 | Condition decision |
| fn_invalid_o | output | 1 | Undefined operation or condition code |

## Verification
`result_o` and `fn_invalid_o` settle in the same cycle as their inputs, so the bench changes operands on the falling edge and samples them 1 ns later. The flags change only at the next rising edge, so they are sampled 1 ns after that edge, once the strobe has been lowered. The condition decision depends on the stored flags, so all sixteen condition codes are then swept in 1 ns steps before the next falling edge. Each step is compared with a model built from the flag values expected after that edge.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  localparam int unsigned FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    ALU_ADD = 4'd0,
    ALU_SUB = 4'd1,
    ALU_AND = 4'd2,
    ALU_XOR = 4'd3
  } alu_fn_e;

  typedef enum logic [FN_W-1:0] {
    CC_ALWAYS = 4'd0,
    CC_LE     = 4'd1,
    CC_LT     = 4'd2,
    CC_EQ     = 4'd3,
    CC_NE     = 4'd4,
    CC_GE     = 4'd5,
    CC_GT     = 4'd6
  } cond_fn_e;

  localparam logic [FN_W-1:0] ALU_LAST  = ALU_XOR;
  localparam logic [FN_W-1:0] COND_LAST = CC_GT;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } cc_flags_t;

  localparam cc_flags_t FLAGS_RST = '{zf: 1'b1, sf: 1'b0, of: 1'b0};
endpackage

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
  import alu_cc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [FN_W-1:0]  fn_i,
  output logic [WIDTH-1:0] result_o,
  output cc_flags_t        flags_o,
  output logic             fn_ok_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic             is_sub;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] xor_v;
  logic             arith_ovf;

  assign is_sub  = (fn_i == ALU_SUB);
  assign fn_ok_o = (fn_i <= ALU_LAST);

  // one adder: b + a, or b + ~a + 1 for b - a
  assign addend = is_sub ? ~op_a_i : op_a_i;
  assign sum    = op_b_i + addend + {{(WIDTH-1){1'b0}}, is_sub};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bitwise
    assign and_v[i] = op_a_i[i] & op_b_i[i];
    assign xor_v[i] = op_a_i[i] ^ op_b_i[i];
  end

  assign arith_ovf = (op_b_i[MSB] == addend[MSB]) && (sum[MSB] != op_b_i[MSB]);

  always_comb begin
    result_o = '0;
    unique case (fn_i)
      ALU_ADD, ALU_SUB: result_o = sum;
      ALU_AND:          result_o = and_v;
      ALU_XOR:          result_o = xor_v;
      default:          result_o = '0;
    endcase
  end

  always_comb begin
    flags_o.zf = (result_o == '0);
    flags_o.sf = result_o[MSB];
    flags_o.of = (fn_i == ALU_ADD || fn_i == ALU_SUB) ? arith_ovf : 1'b0;
  end
endmodule

// File: rtl/alu_cc_flag_reg.sv
module alu_cc_flag_reg
  import alu_cc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  cc_flags_t flags_d_i,
  output cc_flags_t flags_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q_o <= FLAGS_RST;
    else if (load_i) flags_q_o <= flags_d_i;
  end

  a_r4_hold_without_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(flags_q_o));
endmodule

// File: rtl/alu_cc_cond_eval.sv
module alu_cc_cond_eval
  import alu_cc_pkg::*;
(
  input  logic [FN_W-1:0] cond_fn_i,
  input  cc_flags_t       flags_i,
  output logic            cond_true_o,
  output logic            fn_ok_o
);
  logic lt;

  assign lt      = flags_i.sf ^ flags_i.of;
  assign fn_ok_o = (cond_fn_i <= COND_LAST);

  always_comb begin
    cond_true_o = 1'b0;
    unique case (cond_fn_i)
      CC_ALWAYS: cond_true_o = 1'b1;
      CC_LE:     cond_true_o = lt | flags_i.zf;
      CC_LT:     cond_true_o = lt;
      CC_EQ:     cond_true_o = flags_i.zf;
      CC_NE:     cond_true_o = ~flags_i.zf;
      CC_GE:     cond_true_o = ~lt;
      CC_GT:     cond_true_o = ~lt & ~flags_i.zf;
      default:   cond_true_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [FN_W-1:0]  alu_fn_i,
  input  logic             set_cc_i,
  input  logic [FN_W-1:0]  cond_fn_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zf_o,
  output logic             sf_o,
  output logic             of_o,
  output logic             cond_true_o,
  output logic             fn_invalid_o
);
  cc_flags_t flags_d, flags_q;
  logic      alu_ok, cond_ok;

  alu_cc_datapath #(.WIDTH(WIDTH)) i_datapath (
    .op_a_i  (op_a_i),
    .op_b_i  (op_b_i),
    .fn_i    (alu_fn_i),
    .result_o(result_o),
    .flags_o (flags_d),
    .fn_ok_o (alu_ok)
  );

  // undefined operations never touch the flags
  alu_cc_flag_reg i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (set_cc_i & alu_ok),
    .flags_d_i(flags_d),
    .flags_q_o(flags_q)
  );

  alu_cc_cond_eval i_cond (
    .cond_fn_i  (cond_fn_i),
    .flags_i    (flags_q),
    .cond_true_o(cond_true_o),
    .fn_ok_o    (cond_ok)
  );

  assign zf_o         = flags_q.zf;
  assign sf_o         = flags_q.sf;
  assign of_o         = flags_q.of;
  assign fn_invalid_o = ~alu_ok | ~cond_ok;

  a_r2_zf_tracks_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(set_cc_i && alu_fn_i <= 4'd3) |-> zf_o == ($past(result_o) == '0));
  a_r3_logic_clears_of: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(set_cc_i && (alu_fn_i == 4'd2 || alu_fn_i == 4'd3)) |-> !of_o);
  a_r6_eq_needs_zf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_fn_i == 4'd3 && cond_true_o) |-> zf_o);
  a_r7_bad_alu_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_fn_i > 4'd3) |-> (result_o == '0 && fn_invalid_o));
  a_r7_bad_alu_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(set_cc_i && alu_fn_i > 4'd3) |-> $stable({zf_o, sf_o, of_o}));
  a_r8_bad_cond_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_fn_i > 4'd6) |-> (!cond_true_o && fn_invalid_o));
endmodule

// File: tb/test_alu_cc_unit.sv
`timescale 1ns/1ps
module test_alu_cc_unit;
  localparam int CLK_PERIOD = 40;
  localparam int N_RANDOM   = 1500;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  alu_fn = '0, cond_fn = '0;
  logic        set_cc = 1'b0;
  logic [31:0] result;
  logic        zf, sf, of, cond_true, fn_invalid;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  bit m_zf = 1'b1, m_sf = 1'b0, m_of = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_cc_unit i_alu_cc_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(op_a), .op_b_i(op_b),
    .alu_fn_i(alu_fn), .set_cc_i(set_cc), .cond_fn_i(cond_fn),
    .result_o(result), .zf_o(zf), .sf_o(sf), .of_o(of),
    .cond_true_o(cond_true), .fn_invalid_o(fn_invalid)
  );

  function automatic logic [31:0] ref_res(input logic [31:0] a, b, input logic [3:0] f);
    case (f)
      4'd0: return b + a;
      4'd1: return b - a;
      4'd2: return a & b;
      4'd3: return a ^ b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit ref_of(input logic [31:0] a, b, input logic [3:0] f);
    logic [31:0] r;
    r = ref_res(a, b, f);
    if (f == 4'd0) return (a[31] == b[31]) && (r[31] != a[31]);
    if (f == 4'd1) return (a[31] != b[31]) && (r[31] != b[31]);
    return 1'b0;
  endfunction

  function automatic bit ref_cond(input logic [3:0] c, input bit z, s, o);
    case (c)
      4'd0: return 1'b1;
      4'd1: return (s ^ o) | z;
      4'd2: return s ^ o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !(s ^ o);
      4'd6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h fn=%0d cond=%0d)",
               req, act, exp, op_a, op_b, alu_fn, cond_fn);
    end
  endtask

  task automatic sweep_cond();
    for (int c = 0; c < 16; c++) begin
      cond_fn = 4'(c);
      #1;
      if (c > 6) check("R8 cond", {31'd0, cond_true}, 32'd0);
      else       check("R6 cond", {31'd0, cond_true}, {31'd0, ref_cond(4'(c), m_zf, m_sf, m_of)});
      check((c > 6) ? "R8 invalid" : (alu_fn > 3 ? "R7 invalid" : "R9 invalid"),
            {31'd0, fn_invalid}, {31'd0, (c > 6) || (alu_fn > 3)});
    end
  endtask

  // drive at falling edge, check combinational result, then flags after rising edge
  task automatic apply(input logic [31:0] a, b, input logic [3:0] f, input bit sc);
    logic [31:0] r;
    @(negedge clk);
    op_a = a; op_b = b; alu_fn = f; set_cc = sc; cond_fn = 4'd0;
    #1;
    r = ref_res(a, b, f);
    check(f > 3 ? "R7 result" : "R1 result", result, r);
    check(f > 3 ? "R7 invalid" : "R9 invalid", {31'd0, fn_invalid}, {31'd0, f > 3});
    @(posedge clk);
    if (sc && f <= 3) begin
      m_zf = (r == 0); m_sf = r[31]; m_of = ref_of(a, b, f);
    end
    #1;
    set_cc = 1'b0;
    check(sc && f <= 3 ? "R2 zf" : (sc ? "R7 hold zf" : "R4 hold zf"), {31'd0, zf}, {31'd0, m_zf});
    check(sc && f <= 3 ? "R2 sf" : (sc ? "R7 hold sf" : "R4 hold sf"), {31'd0, sf}, {31'd0, m_sf});
    check(sc && f <= 3 ? "R3 of" : (sc ? "R7 hold of" : "R4 hold of"), {31'd0, of}, {31'd0, m_of});
    sweep_cond();
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    #(CLK_PERIOD * 2 + 3);
    // R5 reset state
    check("R5 zf", {31'd0, zf}, 32'd1);
    check("R5 sf", {31'd0, sf}, 32'd0);
    check("R5 of", {31'd0, of}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    sweep_cond();

    // R3 add overflow positive
    apply(32'h7fff_ffff, 32'h0000_0001, 4'd0, 1'b1);
    // R3 add overflow negative, zero result
    apply(32'h8000_0000, 32'h8000_0000, 4'd0, 1'b1);
    // R3 sub overflow: 0x80000000 - 1
    apply(32'h0000_0001, 32'h8000_0000, 4'd1, 1'b1);
    // R3 sub overflow: 0x7fffffff - (-1)
    apply(32'hffff_ffff, 32'h7fff_ffff, 4'd1, 1'b1);
    // R1 sub minuend order, equal -> zero
    apply(32'h1234_5678, 32'h1234_5678, 4'd1, 1'b1);
    apply(32'h0000_0005, 32'h0000_0003, 4'd1, 1'b1);
    // R3 logic ops clear OF
    apply(32'h7fff_ffff, 32'h0000_0001, 4'd0, 1'b1);
    apply(32'hf0f0_f0f0, 32'hff00_ff00, 4'd2, 1'b1);
    apply(32'haaaa_aaaa, 32'haaaa_aaaa, 4'd3, 1'b1);
    // R4 hold with strobe low
    apply(32'h0000_0000, 32'h8000_0000, 4'd0, 1'b0);
    // R7 invalid ALU codes with strobe: no flag change
    for (int f = 4; f < 16; f++) apply(32'h8000_0000, 32'h8000_0000, 4'(f), 1'b1);

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] a, b;
      logic [3:0]  f;
      int sel;
      a = $urandom(); b = $urandom();
      sel = $urandom_range(0, 9);
      if (sel == 0) b = a;
      else if (sel == 1) a = 32'h8000_0000 ^ ($urandom() & 32'h0000_000f);
      f = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(4, 15)) : 4'($urandom_range(0, 3));
      apply(a, b, f, $urandom_range(0, 3) != 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule